// File: doc/BRIEF.md
# Interleaved multi-bank shift register

This block is a serial delay line. At the ports it behaves exactly like an ordinary shift register of `DEPTH` stages that is clocked on every cycle. Inside, the chain is split into `WAYS` banks of `DEPTH/WAYS` stages each. Any one bank advances only on every `WAYS`-th cycle, so each storage flop updates at one `WAYS`-th of the input rate. The flops stay at full supply voltage; only how often they update is reduced.

A phase counter runs modulo `WAYS` and drives two things. It picks the single bank that captures the incoming word on the current cycle, so words are dealt round-robin. It also sets the select of an output multiplexer that picks the bank whose tail holds the word now due. The design uses one clock. Per-bank enables stand in for the slower divided clocks.

The supported degrees of parallelism are 1, 2 and 4. The default is a 16-stage, 1-bit line split into four banks.

Top module: `interleaved_shreg`

## Requirements
- R1: The word on `din` sampled at rising edge k (counting the first edge after reset release as edge 0) appears on `dout` after edge k+DEPTH-1 and stays there until edge k+DEPTH. This is the same output sequence and latency as a plain DEPTH-stage shift register.
- R2: While `rst_n` is low, `dout` is 0 at once, whatever the clock is doing. After release, `dout` stays 0 until DEPTH edges have passed, whatever `din` carries.
- R3: The phase counter is 0 after reset and advances by one on every edge, wrapping from WAYS-1 back to 0.
- R4: On every cycle exactly one bank is enabled: the bank whose index equals the phase. So the word sampled at edge k is written into bank (k mod WAYS).
- R5: A bank that is not enabled on a cycle keeps all of its stages unchanged across that edge. Each flop therefore updates at most once every WAYS cycles.
- R6: The output multiplexer forwards the tail stage of the bank whose index equals the current phase.
- R7: WAYS must be 1, 2 or 4, and DEPTH must be a multiple of WAYS. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the full input word rate |
| rst_n | input | 1 | Asynchronous active-low reset; clears every bank and the phase |
| din | input | WIDTH | Serial input word, sampled on every rising edge |
| dout | output | WIDTH | Serial output word, delayed by DEPTH cycles |

## Verification
The bound checker carries its own plain shift register. On every cycle it compares `dout` with that register's tail. On every cycle it also checks the phase step and wrap, that exactly one bank is enabled and that it is the one matching the phase, that disabled banks hold their contents, and that the output stays zero during the fill period after reset.

Only the bench scenarios can show the end-to-end sequence for particular data shapes. These are single impulses, runs of ones, and patterns whose period equals or divides the bank count, which would expose a steering or select that is off by one bank. The bench scenarios also cover the immediate effect of a reset asserted in the middle of a stream.

// File: rtl/ilsr_pkg.sv
package ilsr_pkg;

  // Width of an index that must address n items (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Legal degrees of parallelism for the interleaved line.
  function automatic bit ways_ok(input int n);
    return (n == 1) || (n == 2) || (n == 4);
  endfunction

endpackage

// File: rtl/ilsr_phase.sv
module ilsr_phase #(
  parameter int WAYS = 4,
  localparam int PW  = ilsr_pkg::idx_width(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PW-1:0]   phase_o,
  output logic [WAYS-1:0] bank_en_o
);

  localparam logic [PW-1:0] LAST = PW'(WAYS - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  // next-state
  always_comb begin
    if (phase_q == LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PW'(1);
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // decode of the phase into one enable per bank
  for (genvar g = 0; g < WAYS; g++) begin : g_en
    assign bank_en_o[g] = (phase_q == PW'(g));
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/ilsr_bank.sv
module ilsr_bank #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 4,
  localparam int BITS  = STAGES * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] tail_o,
  output logic [BITS-1:0]  contents_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  // next-state: shift by one stage only when this bank's slot comes round
  always_comb begin
    stage_d = stage_q;
    if (en_i) begin
      stage_d[0] = din_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_d[s] = stage_q[s-1];
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign tail_o     = stage_q[STAGES-1];
  assign contents_o = stage_q;

endmodule

// File: rtl/ilsr_outmux.sv
module ilsr_outmux #(
  parameter int WIDTH = 1,
  parameter int WAYS  = 4,
  localparam int PW   = ilsr_pkg::idx_width(WAYS)
) (
  input  logic [WAYS-1:0][WIDTH-1:0] tails_i,
  input  logic [PW-1:0]              sel_i,
  output logic [WIDTH-1:0]           dout_o
);

  always_comb begin
    dout_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_i == PW'(w)) begin
        dout_o = tails_i[w];
      end
    end
  end

endmodule

// File: rtl/interleaved_shreg.sv
module interleaved_shreg #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 16,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int STAGES = DEPTH / WAYS;
  localparam int PW     = ilsr_pkg::idx_width(WAYS);
  localparam int BBITS  = STAGES * WIDTH;

  // R7: configuration check at elaboration
  if (!ilsr_pkg::ways_ok(WAYS) || (DEPTH % WAYS) != 0 || DEPTH < WAYS) begin : g_bad_cfg
    $error("interleaved_shreg: WAYS must be 1, 2 or 4 and divide DEPTH");
  end

  logic [PW-1:0]                phase;
  logic [WAYS-1:0]              bank_en;
  logic [WAYS-1:0][WIDTH-1:0]   bank_tail;
  logic [WAYS-1:0][BBITS-1:0]   bank_flat;

  ilsr_phase #(
    .WAYS(WAYS)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_o   (phase),
    .bank_en_o (bank_en)
  );

  for (genvar b = 0; b < WAYS; b++) begin : g_bank
    ilsr_bank #(
      .WIDTH  (WIDTH),
      .STAGES (STAGES)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (bank_en[b]),
      .din_i      (din),
      .tail_o     (bank_tail[b]),
      .contents_o (bank_flat[b])
    );
  end

  ilsr_outmux #(
    .WIDTH (WIDTH),
    .WAYS  (WAYS)
  ) u_mux (
    .tails_i (bank_tail),
    .sel_i   (phase),
    .dout_o  (dout)
  );

endmodule

// File: rtl/interleaved_shreg_chk.sv
module interleaved_shreg_chk #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 16,
  parameter int WAYS  = 4,
  localparam int STAGES = DEPTH / WAYS,
  localparam int PW     = ilsr_pkg::idx_width(WAYS),
  localparam int BBITS  = STAGES * WIDTH,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         din,
  input logic [WIDTH-1:0]         dout,
  input logic [PW-1:0]            phase,
  input logic [WAYS-1:0]          bank_en,
  input logic [WAYS-1:0][BBITS-1:0] bank_flat
);

  // plain shift register used as the equivalence model
  logic [DEPTH-1:0][WIDTH-1:0] plain_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q <= '0;
    end else begin
      plain_q <= {plain_q[DEPTH-2:0], din};
    end
  end

  // edges seen since reset release, saturating at DEPTH
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != CW'(DEPTH)) begin
      since_rst <= since_rst + CW'(1);
    end
  end

  // R1: bit-for-bit match with a plain DEPTH-stage register
  a_r1_equiv: assert property (@(posedge clk) disable iff (!rst_n)
    dout == plain_q[DEPTH-1]);

  // R2: output is zero during the fill period
  a_r2_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CW'(DEPTH)) |-> (dout == '0));

  // R3: phase starts at 0 after reset
  a_r3_phase_start: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == '0) |-> (phase == '0));

  // R3: phase steps by one and wraps
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(phase) == ((int'($past(phase)) + 1) % WAYS)));

  // R4: exactly one bank enabled, the one named by the phase
  a_r4_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_en) == 1) && bank_en[phase]);

  for (genvar b = 0; b < WAYS; b++) begin : g_bank_chk
    // R5: idle banks hold their contents
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en[b] |=> $stable(bank_flat[b]));

    // R4: enabled bank captures the input word in its first stage
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[b] |=> (bank_flat[b][WIDTH-1:0] == $past(din)));
  end

endmodule

bind interleaved_shreg interleaved_shreg_chk #(
  .WIDTH (WIDTH),
  .DEPTH (DEPTH),
  .WAYS  (WAYS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .dout      (dout),
  .phase     (phase),
  .bank_en   (bank_en),
  .bank_flat (bank_flat)
);

// File: tb/tb_interleaved_shreg.sv
module tb_interleaved_shreg;

  localparam int WIDTH = 1;
  localparam int DEPTH = 16;
  localparam int WAYS  = 4;
  localparam int NVEC  = 6;

  // stimulus table: 32-bit pattern streamed MSB first, with the number
  // of ones the bench expects to see come out of the line for it
  localparam logic [31:0] VEC_PAT [NVEC] = '{
    32'h8000_0000,  // single impulse
    32'hFFFF_FFFF,  // run of ones
    32'hAAAA_AAAA,  // period 2
    32'h8888_8888,  // period 4, same bank every time
    32'hC3A5_1E69,  // mixed
    32'h0001_8001   // sparse near the end
  };
  localparam int VEC_ONES [NVEC] = '{1, 32, 16, 8, 16, 3};

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] din;
  logic [WIDTH-1:0] dout;

  interleaved_shreg #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .WAYS  (WAYS)
  ) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .dout  (dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks;
  int n_fail;
  int edges;
  int ones_out;
  logic hist [0:8191];

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: dout=%0b expected %0b", req, edges, act, exp);
    end
  endtask

  // drive one word, let one edge pass, check against the delayed history
  // R1 and through it R3, R4, R5 and R6 (wrong phase, steering, hold or
  // select all break the sequence)
  task automatic step(input logic b, input string req);
    din = b;
    @(posedge clk);
    hist[edges] = b;
    edges++;
    @(negedge clk);
    if (edges >= DEPTH) begin
      check(req, dout, hist[edges-DEPTH]);
    end else begin
      check("R2", dout, 1'b0);
    end
    if (dout === 1'b1) ones_out++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R2", dout, 1'b0);   // immediate clear
    @(negedge clk);
    @(negedge clk);
    check("R2", dout, 1'b0);
    rst_n = 1'b1;
    edges = 0;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    edges    = 0;
    din      = '0;
    rst_n    = 1'b0;
    #1;
    check("R2", dout, 1'b0);   // reset state
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table: each pattern followed by DEPTH zeros to flush it out
    for (int v = 0; v < NVEC; v++) begin
      ones_out = 0;
      for (int i = 31; i >= 0; i--) step(VEC_PAT[v][i], "R1");
      for (int i = 0; i < DEPTH; i++) step(1'b0, "R1");
      n_checks++;
      if (ones_out != VEC_ONES[v]) begin
        n_fail++;
        $display("FAIL R1 vector %0d: ones out=%0d expected %0d", v, ones_out, VEC_ONES[v]);
      end
    end

    // R2: ones from the first edge after reset, zeros for the fill period
    do_reset();
    for (int i = 0; i < DEPTH + 8; i++) step(1'b1, "R2");

    // R2: reset in mid-stream clears the line
    for (int i = 0; i < 5; i++) step(1'b0, "R1");
    do_reset();
    // R3: impulse right after release lands exactly DEPTH edges later,
    // which needs the phase to restart at bank 0 and R6 select to follow
    step(1'b1, "R3");
    for (int i = 0; i < DEPTH + 4; i++) step(1'b0, "R6");

    // R4: impulses on every bank position in turn
    for (int p = 0; p < WAYS; p++) begin
      for (int i = 0; i < p; i++) step(1'b0, "R4");
      step(1'b1, "R4");
      for (int i = 0; i < DEPTH + 3; i++) step(1'b0, "R5");
    end

    // R7 is an elaboration check; the default configuration is legal
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: edges=%0d expected completion", edges);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule